// File: doc/BRIEF.md
# Circular Descriptor Queue Pointer Tracker

This block keeps the two indices of one circular descriptor queue that a host processor and a DMA engine share in memory. The queue holds the entries 0 through a programmable last index, which need not be one less than a power of two. One side produces entries and moves the producer index. The other side consumes them and moves the consumer index. For a free-buffer or pending queue the host produces and the DMA consumes; for a done queue the roles swap. The block itself is neutral and only knows producer and consumer.

Every cycle the block presents the room the producer has left and the number of entries waiting for the consumer. One slot is always kept empty, so equal indices mean an empty queue and the two counts always add up to the last index. It also forms the 32-bit memory address of the entry under each index from a base address and a parameterised entry size: 4 bytes for single-dword entries, 8 bytes for two-dword entries. Software programs the base address, the last index and both indices through a small write port. The block issues no memory transaction itself.

Top module: `ring_ptr_tracker`

## Requirements
- R1: After an asynchronous active-low reset both indices and the base address read 0, the last index reads all ones, and both error flags are low.
- R2: A configuration write (`cfg_we` high) takes effect at the next clock edge. `cfg_sel` selects the target: 0 = base bits 15:0, 1 = base bits 31:16, 2 = last index, 3 = producer index, 4 = consumer index. The index targets take the low `PTR_W` bits of `cfg_wdata`.
- R3: An accepted push moves the producer index up by one. If the index equals the last index, it moves to 0 instead. Otherwise the producer index holds.
- R4: An accepted pop moves the consumer index by the same wrapping rule. Otherwise the consumer index holds.
- R5: The occupancy count is wr − rd when wr ≥ rd, and last + 1 − rd + wr otherwise.
- R6: The free count is rd − wr − 1 when rd > wr, and last − wr + rd otherwise. The free and occupancy counts therefore sum to the last index.
- R7: A push while the free count is 0 is rejected: the producer index holds and `push_err` is high for the one cycle that follows.
- R8: A pop while the occupancy count is 0 is rejected: the consumer index holds and `pop_err` is high for the one cycle that follows.
- R9: A push and a pop in the same cycle are each judged against the counts before that edge. On a full queue the push is rejected and the pop is accepted. On an empty queue the pop is rejected and the push is accepted, provided room exists.
- R10: In a cycle with `cfg_we` high, any push or pop is discarded without moving an index and without raising an error flag.
- R11: `prod_addr` equals base + (producer index << `ENTRY_SHIFT`) and `cons_addr` equals base + (consumer index << `ENTRY_SHIFT`), both taken modulo 2^32. `ENTRY_SHIFT` is 2 for one-dword entries and 3 for two-dword entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration target select |
| cfg_wdata | input | 16 | Configuration write data |
| prod_push | input | 1 | Producer has written one entry |
| cons_pop | input | 1 | Consumer has taken one entry |
| wr_ptr | output | PTR_W | Producer index |
| rd_ptr | output | PTR_W | Consumer index |
| end_idx | output | PTR_W | Last valid entry index |
| base_addr | output | 32 | Queue base address |
| free_cnt | output | PTR_W | Entries the producer may still write |
| occ_cnt | output | PTR_W | Entries waiting for the consumer |
| prod_addr | output | 32 | Memory address of the entry under the producer index |
| cons_addr | output | 32 | Memory address of the entry under the consumer index |
| push_err | output | 1 | A push was rejected in the previous cycle |
| pop_err | output | 1 | A pop was rejected in the previous cycle |

## Verification
A wrong index shows up in the cycle after the faulty edge. It appears at once in the index outputs, in the entry address formed from it, and in both counts. A wrong wrap point shows up when a sweep walks an index past the last entry. A wrong full or empty decision shows up one cycle later as a missing or spurious error flag, together with an index that moved when it should have held. A sweep over every pair of indices under every last index exposes any error in the count formulas at the pair where it occurs.

// File: rtl/ring_pkg.sv
package ring_pkg;

  typedef enum logic [2:0] {
    SEL_BASE_LO = 3'd0,
    SEL_BASE_HI = 3'd1,
    SEL_LAST    = 3'd2,
    SEL_WR      = 3'd3,
    SEL_RD      = 3'd4
  } ring_sel_e;

  // Next index with wrap at the programmed last entry
  function automatic logic [15:0] ring_next(input logic [15:0] p, input logic [15:0] last);
    return (p == last) ? 16'd0 : p + 16'd1;
  endfunction

  // Room left for the producer, one slot always kept empty
  function automatic logic [15:0] ring_free(input logic [15:0] wr, input logic [15:0] rd,
                                            input logic [15:0] last);
    if (rd > wr) return rd - wr - 16'd1;
    else         return last - wr + rd;
  endfunction

  // Entries waiting for the consumer
  function automatic logic [15:0] ring_occ(input logic [15:0] wr, input logic [15:0] rd,
                                           input logic [15:0] last);
    if (wr >= rd) return wr - rd;
    else          return last + 16'd1 - rd + wr;
  endfunction

  function automatic logic [31:0] ring_entry_addr(input logic [31:0] base, input logic [15:0] p,
                                                  input int unsigned shift);
    return base + ({16'd0, p} << shift);
  endfunction

endpackage

// File: rtl/ring_cfg.sv
module ring_cfg
  import ring_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [15:0]      cfg_wdata,
  output logic [31:0]      base_q,
  output logic [PTR_W-1:0] last_q,
  output logic             ld_wr,
  output logic             ld_rd,
  output logic [PTR_W-1:0] ld_val
);
  ring_sel_e sel;
  assign sel    = ring_sel_e'(cfg_sel);
  assign ld_wr  = cfg_we && (sel == SEL_WR);
  assign ld_rd  = cfg_we && (sel == SEL_RD);
  assign ld_val = cfg_wdata[PTR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      last_q <= '1;
    end else if (cfg_we) begin
      case (sel)
        SEL_BASE_LO: base_q[15:0]  <= cfg_wdata;
        SEL_BASE_HI: base_q[31:16] <= cfg_wdata;
        SEL_LAST:    last_q        <= cfg_wdata[PTR_W-1:0];
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/ring_ptr.sv
module ring_ptr
  import ring_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             step,
  input  logic [PTR_W-1:0] last,
  output logic [PTR_W-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= PTR_W'(ring_next(16'(ptr), 16'(last)));
  end
endmodule

// File: rtl/ring_count.sv
module ring_count
  import ring_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic [PTR_W-1:0] wr,
  input  logic [PTR_W-1:0] rd,
  input  logic [PTR_W-1:0] last,
  output logic [PTR_W-1:0] free_cnt,
  output logic [PTR_W-1:0] occ_cnt
);
  assign free_cnt = PTR_W'(ring_free(16'(wr), 16'(rd), 16'(last)));
  assign occ_cnt  = PTR_W'(ring_occ(16'(wr), 16'(rd), 16'(last)));
endmodule

// File: rtl/ring_ptr_tracker.sv
module ring_ptr_tracker
  import ring_pkg::*;
#(
  parameter int PTR_W       = 4,
  parameter int ENTRY_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [15:0]      cfg_wdata,
  input  logic             prod_push,
  input  logic             cons_pop,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] end_idx,
  output logic [31:0]      base_addr,
  output logic [PTR_W-1:0] free_cnt,
  output logic [PTR_W-1:0] occ_cnt,
  output logic [31:0]      prod_addr,
  output logic [31:0]      cons_addr,
  output logic             push_err,
  output logic             pop_err
);
  localparam int NSIDE = 2;  // 0 = producer, 1 = consumer

  logic             ld_wr, ld_rd;
  logic [PTR_W-1:0] ld_val;
  logic             push_acc, pop_acc, push_rej, pop_rej;
  logic             load_v [NSIDE];
  logic             step_v [NSIDE];
  logic [PTR_W-1:0] ptr_v  [NSIDE];
  logic [31:0]      addr_v [NSIDE];

  ring_cfg #(.PTR_W(PTR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .base_q(base_addr), .last_q(end_idx), .ld_wr(ld_wr), .ld_rd(ld_rd), .ld_val(ld_val)
  );

  ring_count #(.PTR_W(PTR_W)) u_count (
    .wr(wr_ptr), .rd(rd_ptr), .last(end_idx), .free_cnt(free_cnt), .occ_cnt(occ_cnt)
  );

  // Named events: accepted and rejected moves
  assign push_acc = prod_push && !cfg_we && (free_cnt != '0);
  assign pop_acc  = cons_pop  && !cfg_we && (occ_cnt  != '0);
  assign push_rej = prod_push && !cfg_we && (free_cnt == '0);
  assign pop_rej  = cons_pop  && !cfg_we && (occ_cnt  == '0);

  assign load_v[0] = ld_wr;
  assign load_v[1] = ld_rd;
  assign step_v[0] = push_acc;
  assign step_v[1] = pop_acc;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    ring_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(load_v[g]), .load_val(ld_val),
      .step(step_v[g]), .last(end_idx), .ptr(ptr_v[g])
    );
    assign addr_v[g] = ring_entry_addr(base_addr, 16'(ptr_v[g]), ENTRY_SHIFT);
  end

  assign wr_ptr    = ptr_v[0];
  assign rd_ptr    = ptr_v[1];
  assign prod_addr = addr_v[0];
  assign cons_addr = addr_v[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_err <= 1'b0;
      pop_err  <= 1'b0;
    end else begin
      push_err <= push_rej;
      pop_err  <= pop_rej;
    end
  end
endmodule

// File: rtl/ring_ptr_tracker_chk.sv
module ring_ptr_tracker_chk #(
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             prod_push,
  input logic             cons_pop,
  input logic             push_acc,
  input logic             pop_acc,
  input logic [PTR_W-1:0] wr_ptr,
  input logic [PTR_W-1:0] rd_ptr,
  input logic [PTR_W-1:0] end_idx,
  input logic [PTR_W-1:0] free_cnt,
  input logic [PTR_W-1:0] occ_cnt,
  input logic             push_err,
  input logic             pop_err
);
  a_r3_wr_step: assert property (@(posedge clk) disable iff (!rst_n)
    push_acc |=> wr_ptr == (($past(wr_ptr) == $past(end_idx)) ? '0 : PTR_W'($past(wr_ptr) + 1'b1)));

  a_r3_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !prod_push) |=> $stable(wr_ptr));

  a_r4_rd_step: assert property (@(posedge clk) disable iff (!rst_n)
    pop_acc |=> rd_ptr == (($past(rd_ptr) == $past(end_idx)) ? '0 : PTR_W'($past(rd_ptr) + 1'b1)));

  a_r4_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !cons_pop) |=> $stable(rd_ptr));

  a_r6_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr <= end_idx && rd_ptr <= end_idx) |->
      ({1'b0, free_cnt} + {1'b0, occ_cnt}) == {1'b0, end_idx});

  a_r7_push_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_push && !cfg_we && free_cnt == '0) |=> (push_err && $stable(wr_ptr)));

  a_r8_pop_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_pop && !cfg_we && occ_cnt == '0) |=> (pop_err && $stable(rd_ptr)));

  a_r10_cfg_first: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (!push_err && !pop_err));
endmodule

bind ring_ptr_tracker ring_ptr_tracker_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .prod_push(prod_push), .cons_pop(cons_pop),
  .push_acc(push_acc), .pop_acc(pop_acc), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
  .end_idx(end_idx), .free_cnt(free_cnt), .occ_cnt(occ_cnt),
  .push_err(push_err), .pop_err(pop_err)
);

// File: tb/ring_ptr_tracker_test.sv
module ring_ptr_tracker_test;
  localparam int PW     = 4;
  localparam int SH     = 3;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = 3'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic push = 1'b0, pop = 1'b0;

  wire [PW-1:0] wr_ptr, rd_ptr, end_idx, free_cnt, occ_cnt;
  wire [31:0]   base_addr, prod_addr, cons_addr;
  wire          push_err, pop_err;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  int          m_wr, m_rd, m_end;
  logic [31:0] m_base;
  bit          m_perr, m_cerr;

  always #(CLK_NS/2) clk = ~clk;

  ring_ptr_tracker #(.PTR_W(PW), .ENTRY_SHIFT(SH)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .prod_push(push), .cons_pop(pop), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .end_idx(end_idx),
    .base_addr(base_addr), .free_cnt(free_cnt), .occ_cnt(occ_cnt), .prod_addr(prod_addr),
    .cons_addr(cons_addr), .push_err(push_err), .pop_err(pop_err)
  );

  task automatic chk(string req, string scn, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (%s) act=%h exp=%h", req, scn, act, exp);
    end
  endtask

  // Model occupancy as distance modulo capacity
  function automatic int m_occ();
    int cap = m_end + 1;
    return (m_wr - m_rd + cap) % cap;
  endfunction

  task automatic check_all(string scn);
    int occ = m_occ();
    chk("R3 wr_ptr", scn, 32'(wr_ptr), 32'(m_wr));
    chk("R4 rd_ptr", scn, 32'(rd_ptr), 32'(m_rd));
    chk("R2 end_idx", scn, 32'(end_idx), 32'(m_end));
    chk("R2 base", scn, base_addr, m_base);
    chk("R5 occ", scn, 32'(occ_cnt), 32'(occ));
    chk("R6 free", scn, 32'(free_cnt), 32'(m_end - occ));
    chk("R11 prod_addr", scn, prod_addr, m_base + 32'(m_wr * (1 << SH)));
    chk("R11 cons_addr", scn, cons_addr, m_base + 32'(m_rd * (1 << SH)));
    chk("R7 push_err", scn, 32'(push_err), 32'(m_perr));
    chk("R8 pop_err", scn, 32'(pop_err), 32'(m_cerr));
  endtask

  task automatic cycle(bit p, bit q, bit we, logic [2:0] sel, logic [15:0] d, string scn);
    int occ, fr, nw, nr;
    cfg_we = we; cfg_sel = sel; cfg_wdata = d; push = p; pop = q;
    occ = m_occ(); fr = m_end - occ;
    nw = m_wr; nr = m_rd;
    m_perr = 1'b0; m_cerr = 1'b0;
    if (we) begin
      case (sel)
        3'd0: m_base[15:0]  = d;
        3'd1: m_base[31:16] = d;
        3'd2: m_end = int'(d[PW-1:0]);
        3'd3: nw = int'(d[PW-1:0]);
        3'd4: nr = int'(d[PW-1:0]);
        default: ;
      endcase
    end else begin
      if (p && fr > 0) nw = (m_wr == m_end) ? 0 : m_wr + 1;
      if (p && fr == 0) m_perr = 1'b1;
      if (q && occ > 0) nr = (m_rd == m_end) ? 0 : m_rd + 1;
      if (q && occ == 0) m_cerr = 1'b1;
    end
    @(negedge clk);
    m_wr = nw; m_rd = nr;
    check_all(scn);
    cfg_we = 1'b0; push = 1'b0; pop = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog (all requirements) act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int ends[5] = '{0, 1, 2, 5, 15};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_wr = 0; m_rd = 0; m_end = (1 << PW) - 1; m_base = 32'd0; m_perr = 0; m_cerr = 0;
    check_all("R1 reset state");

    cycle(0, 0, 1, 3'd0, 16'h1238, "R2 base low");
    cycle(0, 0, 1, 3'd1, 16'hA000, "R2 base high");

    // Exhaustive index pairs under every last index (R5, R6, R11)
    for (int e = 0; e < (1 << PW); e++) begin
      cycle(0, 0, 1, 3'd3, 16'd0, "R2 clear wr");
      cycle(0, 0, 1, 3'd4, 16'd0, "R2 clear rd");
      cycle(0, 0, 1, 3'd2, 16'(e), "R2 last index");
      for (int w = 0; w <= e; w++)
        for (int r = 0; r <= e; r++) begin
          cycle(0, 0, 1, 3'd3, 16'(w), "R5/R6 pair wr");
          cycle(0, 0, 1, 3'd4, 16'(r), "R5/R6 pair rd");
        end
    end

    foreach (ends[i]) begin
      int e = ends[i];
      cycle(0, 0, 1, 3'd3, 16'd0, "R2 clear wr");
      cycle(0, 0, 1, 3'd4, 16'd0, "R2 clear rd");
      cycle(0, 0, 1, 3'd2, 16'(e), "R2 last index");
      if (e == 15) begin
        cycle(0, 0, 1, 3'd0, 16'hFFF0, "R11 wrap base low");
        cycle(0, 0, 1, 3'd1, 16'hFFFF, "R11 wrap base high");
      end
      for (int k = 0; k <= e; k++) cycle(1, 0, 0, 3'd0, 16'd0, "R7 fill to full");
      cycle(1, 1, 0, 3'd0, 16'd0, "R9 push+pop on full");
      for (int k = 0; k <= e + 1; k++) cycle(0, 1, 0, 3'd0, 16'd0, "R8 drain past empty");
      cycle(1, 1, 0, 3'd0, 16'd0, "R9 push+pop on empty");
      cycle(1, 1, 1, 3'd4, 16'd0, "R10 cfg write wins");
      cycle(1, 0, 1, 3'd0, 16'(m_base[15:0]), "R10 push dropped");
      for (int k = 0; k < 200; k++) begin
        bit we = ($urandom_range(15) == 0);
        cycle(1'($urandom_range(1)), 1'($urandom_range(1)), we,
              3'($urandom_range(1)), 16'($urandom_range(65535)), "R3/R4 random traffic");
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule